// File: doc/BRIEF.md
# Two-Level Short-Descriptor Translation Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It walks a two-level page table held in memory. A start pulse hands it the virtual address. The caller also supplies a control word, whose three low bits set the split between the two table bases, and the two table base registers. The walker then issues one or two word reads on a request/acknowledge memory port. It ends with either a one-cycle done pulse, with the physical address on its result port, or a one-cycle fault pulse.

A first-level entry can map the result directly, as a 1 MB section or a 16 MB supersection. It can also point to a second-level table, whose entry maps a 64 KB large page or a 4 KB small page. The split field decides which base register anchors the first-level fetch. The base mask and the address range for that field are held in registers and are recomputed whenever the field changes. The control word and the base registers must stay stable while a walk is in progress.

Top module: `tt_walker`

## Requirements
- R1: After reset, busy, done, fault and memReq are all low.
- R2: Let N be ctlWord[2:0]. Base register 1 is used when the virtual address is strictly greater than (0xFFFFFFFF >> N); otherwise base register 0 is used.
- R3: The first-level fetch address is (base & mask) | ((va & (0xFFF00000 & range)) >> 18). For base 0, mask = 0xFFFFFFFF << (14 − N) and range = 0xFFFFFFFF >> N. For base 1, mask = 0xFFFFFFFF << 14 and range = 0xFFFFFFFF. Every fetch address has bits [1:0] = 00.
- R4: A first-level descriptor with bits [1:0] = 00 ends the walk with a fault pulse.
- R5: A first-level descriptor with bit 1 = 1 and bit 18 = 0 is a section. The result is desc[31:20] followed by va[19:0].
- R6: A first-level descriptor with bit 1 = 1 and bit 18 = 1 is a supersection. If any bit of desc & 0x00F001E0 is set, the walk faults. Otherwise the result is desc[31:24] followed by va[23:0].
- R7: A first-level descriptor with bits [1:0] = 01 points to a second-level table. The second fetch address is {desc[31:10], 10'b0} | (va[19:12] << 2).
- R8: A second-level descriptor with bits [1:0] = 00 faults. A value of 01 is a large page, with result desc[31:16] followed by va[15:0]. A value of 10 or 11 is a small page, with result desc[31:12] followed by va[11:0].
- R9: At most one read is outstanding at a time. memReq and memAddr hold steady until the cycle in which memAck is high, and memData is taken in that cycle.
- R10: busy is high from the cycle after an accepted start until done or fault pulses. Each pulse lasts one cycle, comes in the cycle busy falls, and done and fault are never high together.
- R11: A startReq that arrives while busy is high is ignored. The walk in progress finishes with its own result, and it gives exactly one done or fault pulse.
- R12: The range and mask follow ctlWord[2:0]. A new split value applied in the same cycle as startReq already governs that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctlWord | input | 32 | Translation control word; bits [2:0] are the split N |
| base0 | input | 32 | Table base register 0 |
| base1 | input | 32 | Table base register 1 |
| startReq | input | 1 | Start pulse, accepted when idle |
| vaIn | input | 32 | Virtual address, taken with startReq |
| memReq | output | 1 | Word read request |
| memAddr | output | 32 | Word read address |
| memAck | input | 1 | Read acknowledge; memData is valid with it |
| memData | input | 32 | Read data word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: translation fault |
| paOut | output | 32 | Physical address, held after done |

## Verification
Assertions check on every cycle that the request and its address hold until acknowledge and that every fetch address is word aligned. They also check that done and fault are exclusive and come only as busy falls, that a walk ends only on an acknowledge, and that a section result keeps the low 20 bits of the latched address. Only the bench scenarios can show the rest. This covers the actual fetch addresses for each split value, with the boundary addresses on both sides of the range. It also covers the decoding of every descriptor kind, including a rejected supersection, and the recomputation when the split changes. Last, it shows that a second start during a slow walk leaves the first walk's result unchanged.

// File: rtl/tt_walker_pkg.sv
package tt_walker_pkg;
  localparam int VA_W      = 32;
  localparam int SPLIT_W   = 3;
  localparam int L1_SHIFT  = 14;
  localparam int L1_IDX_SH = 18;
  localparam int SECT_LSB  = 20;
  localparam int SUPER_LSB = 24;
  localparam int LARGE_LSB = 16;
  localparam int SMALL_LSB = 12;
  localparam int L2_PTR_LSB = 10;
  localparam logic [VA_W-1:0] L1_VA_KEEP = {{(VA_W-SECT_LSB){1'b1}}, {SECT_LSB{1'b0}}};
  localparam logic [VA_W-1:0] SUPER_EXT  = 32'h00F0_01E0;

  typedef struct packed {
    logic latchVa;
    logic latchL1;
    logic loadResult;
    logic selL2;
  } walk_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_L1   = 2'd1,
    ST_L2   = 2'd2
  } walk_state_t;
endpackage

// File: rtl/tt_walker_ctrl.sv
module tt_walker_ctrl
  import tt_walker_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startReq,
  input  logic         memAck,
  input  logic         l1Fault,
  input  logic         l1Leaf,
  input  logic         l2Fault,
  output walk_strobe_t strobe,
  output logic         memReq,
  output logic         busy,
  output logic         done,
  output logic         fault
);
  walk_state_t state, stateNext;
  logic doneQ, faultQ, doneNext, faultNext;

  always_comb begin
    strobe    = '0;
    memReq    = 1'b0;
    stateNext = state;
    doneNext  = 1'b0;
    faultNext = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.latchVa = 1'b1;
          stateNext      = ST_L1;
        end
      end
      ST_L1: begin
        memReq = 1'b1;
        if (memAck) begin
          if (l1Fault) begin
            faultNext = 1'b1;
            stateNext = ST_IDLE;
          end else if (l1Leaf) begin
            strobe.loadResult = 1'b1;
            doneNext          = 1'b1;
            stateNext         = ST_IDLE;
          end else begin
            strobe.latchL1 = 1'b1;
            stateNext      = ST_L2;
          end
        end
      end
      ST_L2: begin
        memReq       = 1'b1;
        strobe.selL2 = 1'b1;
        if (memAck) begin
          stateNext = ST_IDLE;
          if (l2Fault) faultNext = 1'b1;
          else begin
            strobe.loadResult = 1'b1;
            doneNext          = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      doneQ  <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      state  <= stateNext;
      doneQ  <= doneNext;
      faultQ <= faultNext;
    end
  end

  assign busy  = (state != ST_IDLE);
  assign done  = doneQ;
  assign fault = faultQ;

  // R10: result pulses are exclusive and appear only once idle again
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(doneQ && faultQ));
  a_r10_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (doneQ || faultQ) |-> !busy);
  // R11: a walk only ends on an acknowledge, never on a new start
  a_r11_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !memAck) |=> busy);
  a_r10_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq) |=> (busy && memReq));
endmodule

// File: rtl/tt_walker_dp.sv
module tt_walker_dp
  import tt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   ctlWord,
  input  logic [VA_W-1:0]   base0,
  input  logic [VA_W-1:0]   base1,
  input  logic [VA_W-1:0]   vaIn,
  input  logic [VA_W-1:0]   memData,
  input  walk_strobe_t      strobe,
  output logic [VA_W-1:0]   memAddr,
  output logic              l1Fault,
  output logic              l1Leaf,
  output logic              l2Fault,
  output logic [VA_W-1:0]   paOut
);
  localparam logic [VA_W-1:0] ALL_ONES = {VA_W{1'b1}};
  localparam logic [VA_W-1:0] MASK1    = ALL_ONES << L1_SHIFT;

  logic [SPLIT_W-1:0] splitSeen;
  logic [VA_W-1:0]    range0Q, mask0Q;
  logic [VA_W-1:0]    vaQ, l1DescQ, paQ;
  logic [SPLIT_W-1:0] splitIn;

  assign splitIn = ctlWord[SPLIT_W-1:0];

  // R12: range and mask registers refresh whenever the split field moves
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      splitSeen <= '0;
      range0Q   <= ALL_ONES;
      mask0Q    <= MASK1;
    end else if (splitIn != splitSeen) begin
      splitSeen <= splitIn;
      range0Q   <= ALL_ONES >> splitIn;
      mask0Q    <= ALL_ONES << (L1_SHIFT - int'(splitIn));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaQ     <= '0;
      l1DescQ <= '0;
    end else begin
      if (strobe.latchVa) vaQ     <= vaIn;
      if (strobe.latchL1) l1DescQ <= memData;
    end
  end

  // R2, R3: base selection and first-level fetch address
  logic            useBase1;
  logic [VA_W-1:0] selBase, selMask, selRange, l1Addr, l2Addr;
  assign useBase1 = (vaQ > range0Q);
  assign selBase  = useBase1 ? base1 : base0;
  assign selMask  = useBase1 ? MASK1 : mask0Q;
  assign selRange = useBase1 ? ALL_ONES : range0Q;
  assign l1Addr   = (selBase & selMask) | ((vaQ & (L1_VA_KEEP & selRange)) >> L1_IDX_SH);
  // R7: second-level fetch address
  assign l2Addr   = {l1DescQ[VA_W-1:L2_PTR_LSB], {L2_PTR_LSB{1'b0}}}
                  | {{(VA_W-10){1'b0}}, vaQ[SECT_LSB-1:SMALL_LSB], 2'b00};
  assign memAddr  = strobe.selL2 ? l2Addr : l1Addr;

  // R4, R5, R6: first-level decode
  logic isSuper, l1Invalid, superBad;
  logic [VA_W-1:0] l1Pa, l2Pa;
  assign l1Invalid = (memData[1:0] == 2'b00);
  assign isSuper   = memData[1] && memData[18];
  assign superBad  = isSuper && ((memData & SUPER_EXT) != '0);
  assign l1Fault   = l1Invalid || superBad;
  assign l1Leaf    = memData[1];
  assign l1Pa      = isSuper
                   ? {memData[VA_W-1:SUPER_LSB], vaQ[SUPER_LSB-1:0]}
                   : {memData[VA_W-1:SECT_LSB], vaQ[SECT_LSB-1:0]};

  // R8: second-level decode
  assign l2Fault = (memData[1:0] == 2'b00);
  assign l2Pa    = (memData[1:0] == 2'b01)
                 ? {memData[VA_W-1:LARGE_LSB], vaQ[LARGE_LSB-1:0]}
                 : {memData[VA_W-1:SMALL_LSB], vaQ[SMALL_LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) paQ <= '0;
    else if (strobe.loadResult) paQ <= strobe.selL2 ? l2Pa : l1Pa;
  end
  assign paOut = paQ;

  // R5: a first-level leaf result keeps at least the low section offset of the address
  a_r5_section_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadResult && !strobe.selL2) |=> (paQ[SECT_LSB-1:0] == $past(vaQ[SECT_LSB-1:0])));
endmodule

// File: rtl/tt_walker.sv
module tt_walker
  import tt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   ctlWord,
  input  logic [VA_W-1:0]   base0,
  input  logic [VA_W-1:0]   base1,
  input  logic              startReq,
  input  logic [VA_W-1:0]   vaIn,
  output logic              memReq,
  output logic [VA_W-1:0]   memAddr,
  input  logic              memAck,
  input  logic [VA_W-1:0]   memData,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [VA_W-1:0]   paOut
);
  walk_strobe_t strobe;
  logic l1Fault, l1Leaf, l2Fault;

  tt_walker_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .memAck(memAck),
    .l1Fault(l1Fault), .l1Leaf(l1Leaf), .l2Fault(l2Fault),
    .strobe(strobe), .memReq(memReq), .busy(busy), .done(done), .fault(fault)
  );

  tt_walker_dp u_dp (
    .clk(clk), .rst_n(rst_n), .ctlWord(ctlWord), .base0(base0), .base1(base1),
    .vaIn(vaIn), .memData(memData), .strobe(strobe), .memAddr(memAddr),
    .l1Fault(l1Fault), .l1Leaf(l1Leaf), .l2Fault(l2Fault), .paOut(paOut)
  );

  // R9: request and address hold until acknowledged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));
  // R3: every fetch is word aligned
  a_r3_align: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> (memAddr[1:0] == 2'b00));
endmodule

// File: tb/tb_tt_walker.sv
module tb_tt_walker;
  typedef struct packed {
    logic [1:0]  lat;
    logic [2:0]  n;
    logic [31:0] b0, b1, va, a1, d1, a2, d2;
    logic        flt;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R5 section, N=0
    '{2'd0, 3'd0, 32'h0000_4000, 32'h0001_0000, 32'h1234_5678, 32'h0000_448C, 32'hABC0_0002, 32'h0, 32'h0, 1'b0, 32'hABC4_5678},
    // R6 supersection accepted
    '{2'd1, 3'd0, 32'h0000_8000, 32'h0001_0000, 32'h8765_4321, 32'h0000_A1D8, 32'h5504_0002, 32'h0, 32'h0, 1'b0, 32'h5565_4321},
    // R6 supersection with extended bits -> fault
    '{2'd2, 3'd0, 32'h0000_8000, 32'h0001_0000, 32'h8765_4321, 32'h0000_A1D8, 32'h5514_0002, 32'h0, 32'h0, 1'b1, 32'h0},
    // R4 invalid first level
    '{2'd0, 3'd0, 32'h0000_4000, 32'h0001_0000, 32'h1234_5678, 32'h0000_448C, 32'hFFFF_FFFC, 32'h0, 32'h0, 1'b1, 32'h0},
    // R7 R8 large page
    '{2'd1, 3'd0, 32'h0000_C000, 32'h0001_0000, 32'h0013_5ABC, 32'h0000_C004, 32'h0002_0401, 32'h0002_04D4, 32'h7777_0001, 1'b0, 32'h7777_5ABC},
    // R8 small page (10)
    '{2'd0, 3'd0, 32'h0000_C000, 32'h0001_0000, 32'h0013_5ABC, 32'h0000_C004, 32'h0002_0401, 32'h0002_04D4, 32'h8888_9002, 1'b0, 32'h8888_9ABC},
    // R8 small page (11)
    '{2'd3, 3'd0, 32'h0000_C000, 32'h0001_0000, 32'h0013_5ABC, 32'h0000_C004, 32'h0002_0401, 32'h0002_04D4, 32'h1234_5003, 1'b0, 32'h1234_5ABC},
    // R8 second level fault
    '{2'd0, 3'd0, 32'h0000_C000, 32'h0001_0000, 32'h0013_5ABC, 32'h0000_C004, 32'h0002_0401, 32'h0002_04D4, 32'h1234_5000, 1'b1, 32'h0},
    // R2 N=2, above range -> base1
    '{2'd0, 3'd2, 32'h0000_3ABC, 32'h0001_0000, 32'h4000_1000, 32'h0001_1000, 32'hCAF0_0002, 32'h0, 32'h0, 1'b0, 32'hCAF0_1000},
    // R3 N=2, base0 masked, range-limited index
    '{2'd1, 3'd2, 32'h0000_3ABC, 32'h0001_0000, 32'h3FF0_0123, 32'h0000_3FFC, 32'hBEE0_0002, 32'h0, 32'h0, 1'b0, 32'hBEE0_0123},
    // R2 boundary: equal to range -> base0
    '{2'd0, 3'd2, 32'h0000_3ABC, 32'h0001_0000, 32'h3FFF_FFFF, 32'h0000_3FFC, 32'hBEE0_0002, 32'h0, 32'h0, 1'b0, 32'hBEEF_FFFF},
    // R2 boundary: one above -> base1
    '{2'd2, 3'd2, 32'h0000_3ABC, 32'h0001_0000, 32'h4000_0000, 32'h0001_1000, 32'hCAF0_0002, 32'h0, 32'h0, 1'b0, 32'hCAF0_0000},
    // R12 split back to 0: same address now uses base0
    '{2'd0, 3'd0, 32'h0000_4000, 32'h0001_0000, 32'h4000_0000, 32'h0000_5000, 32'h1230_0002, 32'h0, 32'h0, 1'b0, 32'h1230_0000},
    // R3 N=7 mask and range
    '{2'd1, 3'd7, 32'h0000_5FFF, 32'h0001_0000, 32'h01E0_0010, 32'h0000_5FF8, 32'h9990_0002, 32'h0, 32'h0, 1'b0, 32'h9990_0010}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ctlWord = '0, base0 = '0, base1 = '0, vaIn = '0;
  logic startReq = 1'b0;
  logic memReq, memAck, busy, done, fault;
  logic [31:0] memAddr, memData, paOut;

  int checks = 0;
  int failures = 0;
  int holdErrs = 0;
  logic [1:0]  curLat = '0;
  logic [31:0] curA1 = '0, curD1 = '0, curA2 = '0, curD2 = '0;

  always #5 clk = ~clk;

  tt_walker dut (
    .clk(clk), .rst_n(rst_n), .ctlWord(ctlWord), .base0(base0), .base1(base1),
    .startReq(startReq), .vaIn(vaIn), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memData(memData), .busy(busy), .done(done), .fault(fault),
    .paOut(paOut)
  );

  // Memory responder: unknown addresses return 0, which decodes as a fault
  logic [1:0] waitCnt = '0;
  initial begin
    memAck  = 1'b0;
    memData = '0;
    forever begin
      @(posedge clk);
      if (memReq && !memAck) begin
        if (waitCnt == curLat) begin
          memAck  <= 1'b1;
          memData <= (memAddr == curA1) ? curD1 : (memAddr == curA2) ? curD2 : 32'h0;
          waitCnt <= '0;
        end else waitCnt <= waitCnt + 2'd1;
      end else begin
        memAck  <= 1'b0;
        waitCnt <= '0;
      end
    end
  end

  // R9 monitor: while a request waits, its address must not move
  logic        prevWait = 1'b0;
  logic [31:0] prevAddr = '0;
  always @(negedge clk) begin
    if (rst_n && prevWait && (!memReq || memAddr != prevAddr)) holdErrs++;
    prevWait = memReq && !memAck;
    prevAddr = memAddr;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_vec(input vec_t v);
    ctlWord = {29'd0, v.n};
    base0 = v.b0; base1 = v.b1; vaIn = v.va;
    curLat = v.lat; curA1 = v.a1; curD1 = v.d1; curA2 = v.a2; curD2 = v.d2;
  endtask

  task automatic wait_result(output logic gotDone, output logic gotFault);
    int n = 0;
    gotDone = 1'b0; gotFault = 1'b0;
    while (!(done || fault) && n < 60) begin
      @(negedge clk);
      n++;
    end
    gotDone = done; gotFault = fault;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic gd, gf;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {28'd0, busy, done, fault, memReq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset release", {28'd0, busy, done, fault, memReq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      load_vec(VECS[i]);
      startReq = 1'b1;        // R12: split applied together with start
      @(negedge clk);
      startReq = 1'b0;
      check($sformatf("R10 busy after start v%0d", i), {31'd0, busy}, 32'h1);
      wait_result(gd, gf);
      check($sformatf("R4 R6 R8 fault flag v%0d", i), {31'd0, gf}, {31'd0, VECS[i].flt});
      check($sformatf("R10 done flag v%0d", i), {31'd0, gd}, {31'd0, ~VECS[i].flt});
      check($sformatf("R10 busy low at result v%0d", i), {31'd0, busy}, 32'h0);
      if (!VECS[i].flt)
        check($sformatf("R2 R3 R5 R7 result v%0d", i), paOut, VECS[i].pa);
      @(negedge clk);
      check($sformatf("R10 single-cycle pulse v%0d", i), {30'd0, done, fault}, 32'h0);
    end

    // R11: second start during a slow two-level walk is ignored
    begin
      int pulses = 0;
      load_vec(VECS[4]);
      curLat = 2'd3;
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      @(negedge clk);
      vaIn = 32'h1234_5678;
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      check("R11 still busy after ignored start", {31'd0, busy}, 32'h1);
      for (int k = 0; k < 30; k++) begin
        if (done || fault) pulses++;
        @(negedge clk);
      end
      check("R11 exactly one result pulse", pulses, 1);
      check("R11 result of first walk", paOut, VECS[4].pa);
      check("R11 idle afterwards", {31'd0, busy}, 32'h0);
    end

    check("R9 address held while waiting", holdErrs, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule